// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Window

This block holds the host-visible control registers of a two-channel bus-master storage DMA controller. A small register bus addresses 32-bit words and uses byte enables, so a host can access the registers with 8-, 16- or 32-bit reads and writes. Each channel owns an 8-byte window. The window holds a command byte, a status byte and a 32-bit descriptor-table base address. The run flag, the transfer direction and the table base go straight to a DMA engine outside this block.

The status byte mixes three kinds of bit. Bits 6 and 5 are scratch bits the host can write. Bit 0 is the channel-active flag, which the host cannot write directly. Bits 2 and 1 are latched event flags that the host clears by writing a 1 to them. The engine reports its progress through one-cycle event inputs: transfer done, error and interrupt. Each channel has an interrupt request output that follows its latched interrupt flag.

Top module: `busmaster_regs`

## Requirements
- R1: Channel c occupies byte offsets 8c to 8c+7. `bus_addr` bit 2 selects the word in the window and the bits above it select the channel. `bus_addr[1:0]` is ignored and byte lane k of a word is byte offset k. An access to one channel never changes another channel.
- R2: A read returns the whole word in `bus_rdata` after the clock edge that samples `bus_rd`. In word 0, lane 0 is the command byte, lane 2 is the status byte, and lanes 1 and 3 are always 0xFF.
- R3: A status write (lane 2 enabled) loads status bits 6 and 5 from the written byte. It leaves bit 0 unchanged. Status bits 7, 4 and 3 always read 0.
- R4: A status write clears status bit 1 and/or bit 2 wherever the written byte has a 1. A 0 leaves the bit unchanged.
- R5: Word 1 is the descriptor-table base. Each enabled lane loads its byte, so 8-, 16- and 32-bit writes all work. Base bits 1:0 always read 0. `dma_base` carries the stored base.
- R6: The command byte keeps only bit 0 (run) and bit 3 (direction) and reads 0 elsewhere. A command write with bit 0 set sets `dma_run` and status bit 0. A command write with bit 0 clear clears both. A `ev_done` pulse clears status bit 0 only. `dma_dir` follows command bit 3.
- R7: An `ev_err` pulse sets status bit 1 and an `ev_irq` pulse sets status bit 2. If a set event and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R8: `irq[c]` is high exactly while status bit 2 of channel c is 1.
- R9: After a synchronous reset, every command, status and base register reads 0 and all outputs are low. The reserved lanes still read 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, lane k in bits 8k+7:8k |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| ev_err | input | NCH | Per-channel error event pulse |
| ev_irq | input | NCH | Per-channel interrupt event pulse |
| ev_done | input | NCH | Per-channel transfer-finished pulse |
| dma_run | output | NCH | Per-channel run command |
| dma_dir | output | NCH | Per-channel direction select |
| dma_base | output | 32*NCH | Descriptor-table bases, channel c in bits 32c+31:32c |
| irq | output | NCH | Per-channel interrupt request |

## Verification
The hardest case to reach is a hardware event and a host write-one-to-clear landing on the same status bit in the same clock cycle. In that case the set event must win. The bench reaches it by driving the event pulse and the status write on the same falling edge, so both are sampled by one rising edge. It then reads the status byte back and watches `irq`. A second hard point is that a `ev_done` pulse drops the active flag but must leave the run command set. The bench checks this through the command byte and the `dma_run` output.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  localparam int WIN_BYTES = 8;
  localparam int LANES     = 4;
  localparam int LANE_CMD  = 0;
  localparam int LANE_STAT = 2;
  localparam logic [7:0] RSVD_BYTE = 8'hFF;

  typedef struct packed {
    logic [1:0] scratch;  // status bits 6:5
    logic       intr;     // status bit 2
    logic       err;      // status bit 1
    logic       act;      // status bit 0
  } stat_t;

  function automatic logic [7:0] stat_to_byte(stat_t s);
    return {1'b0, s.scratch, 2'b00, s.intr, s.err, s.act};
  endfunction
endpackage

// File: rtl/bmr_decode.sv
module bmr_decode #(
  parameter int NCH    = 2,
  parameter int ADDR_W = 4,
  parameter int CH_W   = 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic [NCH-1:0]    wr_lo,
  output logic [NCH-1:0]    wr_hi,
  output logic [CH_W-1:0]   ch_idx,
  output logic              word_hi
);
  assign ch_idx  = CH_W'(addr >> 3);
  assign word_hi = addr[2];

  for (genvar c = 0; c < NCH; c++) begin : g_sel
    assign wr_lo[c] = wr && (32'(ch_idx) == c) && !word_hi;
    assign wr_hi[c] = wr && (32'(ch_idx) == c) &&  word_hi;
  end
endmodule

// File: rtl/bmr_chan.sv
module bmr_chan
  import bmr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  input  logic        ev_err,
  input  logic        ev_irq,
  input  logic        ev_done,
  output logic [7:0]  cmd_byte,
  output logic [7:0]  stat_byte,
  output logic [31:0] base,
  output logic        run,
  output logic        dir,
  output logic        irq
);
  stat_t       st;
  logic [31:0] base_q;
  logic        cmd_wr, st_wr;
  logic [7:0]  cmd_in, st_in;

  assign cmd_wr = wr_lo && be[LANE_CMD];
  assign st_wr  = wr_lo && be[LANE_STAT];
  assign cmd_in = wdata[8*LANE_CMD +: 8];
  assign st_in  = wdata[8*LANE_STAT +: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      dir <= 1'b0;
      st  <= '0;
    end else begin
      if (cmd_wr) begin
        run <= cmd_in[0];
        dir <= cmd_in[3];
      end
      if (cmd_wr)       st.act <= cmd_in[0];
      else if (ev_done) st.act <= 1'b0;
      if (st_wr) st.scratch <= st_in[6:5];
      if (ev_err)                 st.err  <= 1'b1;
      else if (st_wr && st_in[1]) st.err  <= 1'b0;
      if (ev_irq)                 st.intr <= 1'b1;
      else if (st_wr && st_in[2]) st.intr <= 1'b0;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [7:0] MASK = (k == 0) ? 8'hFC : 8'hFF;
    always_ff @(posedge clk) begin
      if (rst)                 base_q[8*k +: 8] <= 8'h00;
      else if (wr_hi && be[k]) base_q[8*k +: 8] <= wdata[8*k +: 8] & MASK;
    end
  end

  assign base      = base_q;
  assign cmd_byte  = {4'h0, dir, 2'b00, run};
  assign stat_byte = stat_to_byte(st);
  assign irq       = st.intr;

  p_err_set_r7: assert property (@(posedge clk) disable iff (rst)
    ev_err |=> stat_byte[1]);
  p_irq_set_r7: assert property (@(posedge clk) disable iff (rst)
    ev_irq |=> irq);
  p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
    (st_wr && st_in[2] && !ev_irq) |=> !stat_byte[2]);
  p_start_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && cmd_in[0]) |=> (stat_byte[0] && run));
  p_act_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (st_wr && !cmd_wr && !ev_done) |=> $stable(stat_byte[0]));
endmodule

// File: rtl/busmaster_regs.sv
module busmaster_regs
  import bmr_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = $clog2(NCH * WIN_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic [NCH-1:0]    ev_err,
  input  logic [NCH-1:0]    ev_irq,
  input  logic [NCH-1:0]    ev_done,
  output logic [NCH-1:0]    dma_run,
  output logic [NCH-1:0]    dma_dir,
  output logic [32*NCH-1:0] dma_base,
  output logic [NCH-1:0]    irq
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] wr_lo, wr_hi;
  logic [CH_W-1:0] ch_idx;
  logic            word_hi;
  logic [7:0]      cmd_b  [NCH];
  logic [7:0]      stat_b [NCH];
  logic [31:0]     base_w [NCH];

  bmr_decode #(.NCH(NCH), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .ch_idx(ch_idx), .word_hi(word_hi)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    bmr_chan u_ch (
      .clk(clk), .rst(rst), .wr_lo(wr_lo[c]), .wr_hi(wr_hi[c]),
      .be(bus_be), .wdata(bus_wdata),
      .ev_err(ev_err[c]), .ev_irq(ev_irq[c]), .ev_done(ev_done[c]),
      .cmd_byte(cmd_b[c]), .stat_byte(stat_b[c]), .base(base_w[c]),
      .run(dma_run[c]), .dir(dma_dir[c]), .irq(irq[c])
    );
    assign dma_base[32*c +: 32] = base_w[c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (32'(ch_idx) >= NCH)
        bus_rdata <= '1;
      else if (word_hi)
        bus_rdata <= base_w[ch_idx];
      else
        bus_rdata <= {RSVD_BYTE, stat_b[ch_idx], RSVD_BYTE, cmd_b[ch_idx]};
    end
  end

  p_rsvd_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_addr[2]) |=> (bus_rdata[15:8] == 8'hFF && bus_rdata[31:24] == 8'hFF));
  p_base_align_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[2]) |=> (bus_rdata[1:0] == 2'b00));
endmodule

// File: tb/busmaster_regs_tb.sv
module busmaster_regs_tb;
  localparam int NCH = 2;
  localparam int AW  = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [3:0]    bus_be = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_rdata;
  logic [NCH-1:0] ev_err = '0, ev_irq = '0, ev_done = '0;
  logic [NCH-1:0] dma_run, dma_dir, irq;
  logic [32*NCH-1:0] dma_base;

  int checks = 0;
  int errors = 0;
  logic [31:0] rd_v;

  always #2 clk = ~clk;

  busmaster_regs #(.NCH(NCH)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .ev_err(ev_err), .ev_irq(ev_irq),
    .ev_done(ev_done), .dma_run(dma_run), .dma_dir(dma_dir),
    .dma_base(dma_base), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic pulse(ref logic [NCH-1:0] sig, input int ch);
    @(negedge clk);
    sig[ch] = 1'b1;
    @(negedge clk);
    sig[ch] = 1'b0;
  endtask

  task automatic t_reset();
    rd(4'h0, rd_v); chk("R9 ch0 word0", rd_v, 32'hFF00FF00);
    rd(4'h4, rd_v); chk("R9 ch0 base", rd_v, 32'h0);
    rd(4'h8, rd_v); chk("R9 ch1 word0", rd_v, 32'hFF00FF00);
    chk("R9 outputs", {dma_run, dma_dir, irq}, 32'h0);
  endtask

  task automatic t_cmd();
    wr(4'h0, 4'b0001, 32'h0000_00FF);
    rd(4'h0, rd_v); chk("R6 start keeps bits 0,3", rd_v, 32'hFF01FF09);
    chk("R6 run/dir out", {dma_run, dma_dir}, 32'b0101);
    rd(4'h8, rd_v); chk("R1 ch1 untouched", rd_v, 32'hFF00FF00);
    wr(4'h0, 4'b0001, 32'h0);
    rd(4'h0, rd_v); chk("R6 stop", rd_v, 32'hFF00FF00);
    wr(4'h9, 4'b0001, 32'h0000_0001);
    pulse(ev_done, 1);
    rd(4'h8, rd_v); chk("R6 done clears active only", rd_v, 32'hFF00FF01);
    chk("R6 run stays after done", 32'(dma_run), 32'b10);
  endtask

  task automatic t_stat();
    wr(4'h0, 4'b0001, 32'h1);
    wr(4'h0, 4'b0100, 32'h00FE_0000);
    rd(4'h0, rd_v); chk("R3 status write masks", rd_v, 32'hFF61FF01);
    pulse(ev_err, 0);
    pulse(ev_irq, 0);
    rd(4'h0, rd_v); chk("R7 events set", rd_v, 32'hFF67FF01);
    chk("R8 irq high", 32'(irq), 32'b01);
    wr(4'h0, 4'b0100, 32'h0062_0000);
    rd(4'h0, rd_v); chk("R4 clear bit1", rd_v, 32'hFF65FF01);
    wr(4'h0, 4'b0100, 32'h0004_0000);
    rd(4'h0, rd_v); chk("R4 clear bit2", rd_v, 32'hFF01FF01);
    chk("R8 irq low", 32'(irq), 32'b00);
  endtask

  task automatic t_race();
    @(negedge clk);
    ev_err[0] = 1'b1; ev_irq[0] = 1'b1;
    bus_addr = 4'h0; bus_be = 4'b0100; bus_wdata = 32'h0006_0000; bus_wr = 1'b1;
    @(negedge clk);
    ev_err[0] = 1'b0; ev_irq[0] = 1'b0; bus_wr = 1'b0; bus_be = '0;
    chk("R7 irq kept on race", 32'(irq), 32'b01);
    rd(4'h0, rd_v); chk("R7 set beats clear", rd_v, 32'hFF07FF01);
  endtask

  task automatic t_addr();
    wr(4'hC, 4'b1111, 32'h1234_5677);
    rd(4'hC, rd_v); chk("R5 32-bit write aligned", rd_v, 32'h1234_5674);
    wr(4'hE, 4'b1100, 32'hABCD_0000);
    rd(4'hC, rd_v); chk("R5 16-bit write", rd_v, 32'hABCD_5674);
    wr(4'hD, 4'b0010, 32'h0000_EE00);
    rd(4'hC, rd_v); chk("R5 8-bit write", rd_v, 32'hABCD_EE74);
    chk("R5 dma_base ch1", dma_base[63:32], 32'hABCD_EE74);
    rd(4'h4, rd_v); chk("R1 ch0 base untouched", rd_v, 32'h0);
    wr(4'h8, 4'b1010, 32'hFFFF_FFFF);
    rd(4'h8, rd_v); chk("R2 reserved lanes not writable", rd_v, 32'hFF00FF01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_cmd();
    t_stat();
    t_race();
    t_addr();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule